// File: doc/BRIEF.md
# Adaptive Decay Tuning Controller

This block sets how the off time of a fixed-off-time current chopper is split between fast and slow decay, and it can change that split on every PWM cycle. The current sensing sits outside the block. It receives three one-cycle digital events:

- a pulse that starts each PWM drive phase,
- a pulse when the winding current reaches the trip level,
- a flag raised when the current overshoots that level.

The block measures each drive phase with a clock counter. At the start of the next PWM cycle it grades the cycle that has just ended:

- If the cycle overshot, decay becomes more aggressive.
- If the drive phase took longer than a programmable threshold, decay becomes less aggressive.
- Otherwise the setting is held.

The result is a 4-bit fast-decay share in sixteenths of the off time. A value of 0 means slow decay only and 15 means fast decay only. The downstream off-time sequencer uses it to switch from fast to slow decay partway through the off time.

Tuning is switched on by an enable pin. That pin is read only at power-up or when the block leaves sleep. While tuning is active, the fixed decay select pins have no effect. When tuning is off, those pins select a constant share.

Top module: `adt_decay_tuner`

## Requirements
- R1: The tuning enable pin is captured only on the first clock edge at which `sleep_n` is high after reset or after sleep. Changes on the pin while the block is awake do not affect `tune_active` or the share.
- R2: While `tune_active` is 1, `fast_share` equals the tuned share and `fixed_sel` has no effect on it.
- R3: The tuned share changes only on a `pwm_start` edge that follows an earlier `pwm_start` since wake-up. The first `pwm_start` after wake-up, and any cycle with neither overshoot nor long drive, leave it unchanged.
- R4: If `overshoot` was seen during a cycle, the share increases by 1 at the next cycle boundary.
- R5: Drive length is the number of clock edges from the `pwm_start` edge to the first `trip` edge, or to the next `pwm_start` edge if no trip arrives. If that length exceeds `long_thresh` and there was no overshoot, the share decreases by 1 at the boundary.
- R6: When a cycle has both overshoot and a long drive, the share increases.
- R7: The share saturates at 15 going up and at 0 going down.
- R8: At every wake-up, including the first one after reset, the share is loaded with 8.
- R9: While asleep, and during reset, `fast_share` is 0 and `tune_active` is 0. Awake with tuning off, `fixed_sel` maps as follows: 2'b00 gives 0 (slow), 2'b01 gives 15 (fast), 2'b10 gives `MIX_SHARE` (default 5, about 30 %), and 2'b11 gives 0.
- R10: A drive length exactly equal to `long_thresh` is not long, and the share is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | High = awake; its rising level triggers wake-up capture |
| tune_pin | input | 1 | Tuning enable, captured at wake-up |
| fixed_sel | input | 2 | Fixed decay select used when tuning is off |
| pwm_start | input | 1 | One-cycle pulse at the start of each PWM drive phase |
| trip | input | 1 | One-cycle pulse when current reaches the trip level |
| overshoot | input | 1 | Current overshot the trip level in this cycle |
| long_thresh | input | CNT_W | Long-drive threshold in clock cycles |
| fast_share | output | 4 | Fast-decay share of the off time, in sixteenths |
| tune_active | output | 1 | Tuning captured and block awake |

## Verification
The assertions assume the following about the inputs:

- `pwm_start` and `trip` are single-cycle pulses.
- At most one trip arrives per PWM cycle, and never on the same edge as `pwm_start`.
- `long_thresh` stays constant within a PWM cycle.

The stimulus keeps to these limits. Every pulse is raised on one falling clock edge and cleared on the next. Each trip is placed a chosen number of edges after the cycle start, followed by two idle cycles. The threshold is held at 10 for the whole run.

// File: rtl/adt_pkg.sv
package adt_pkg;
    localparam int SHARE_W = 4;
    typedef logic [SHARE_W-1:0] share_t;
    localparam share_t SHARE_MAX = share_t'((1 << SHARE_W) - 1);
    localparam share_t SHARE_MID = share_t'(1 << (SHARE_W - 1));
    localparam share_t SHARE_MIN = '0;

    typedef enum logic [1:0] {
        SEL_SLOW  = 2'b00,
        SEL_FAST  = 2'b01,
        SEL_MIXED = 2'b10,
        SEL_RSVD  = 2'b11
    } fixed_sel_e;

    typedef struct packed {
        logic awake;
        logic tune;
    } wake_st_t;
endpackage

// File: rtl/adt_wake_latch.sv
module adt_wake_latch
    import adt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    input  logic tune_pin,
    output logic awake,
    output logic tune_on,
    output logic wake_now
);
    wake_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!sleep_n) begin
            st_d.awake = 1'b0;
        end else if (!st_q.awake) begin
            st_d.awake = 1'b1;
            st_d.tune  = tune_pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign awake    = st_q.awake;
    assign tune_on  = st_q.awake & st_q.tune;
    assign wake_now = sleep_n & ~st_q.awake;

    AST_TUNE_HELD_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.awake && sleep_n) |=> $stable(st_q.tune)); // R1
    AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> !tune_on); // R9
endmodule

// File: rtl/adt_drive_monitor.sv
module adt_drive_monitor #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pwm_start,
    input  logic             trip,
    input  logic             overshoot,
    input  logic [CNT_W-1:0] long_thresh,
    output logic             cycle_end,
    output logic             ov_seen,
    output logic             long_seen
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             started;
        logic             driving;
        logic             ov;
        logic             lng;
        logic [CNT_W-1:0] cnt;
    } mon_st_t;

    mon_st_t st_q, st_d;
    logic    over_now;

    always_comb begin
        over_now  = st_q.driving && (st_q.cnt > long_thresh);
        ov_seen   = st_q.ov | overshoot;
        long_seen = st_q.lng | over_now;
        cycle_end = pwm_start & st_q.started;

        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (pwm_start) begin
            st_d.started = 1'b1;
            st_d.driving = 1'b1;
            st_d.cnt     = CNT_ONE;
            st_d.ov      = 1'b0;
            st_d.lng     = 1'b0;
        end else begin
            if (over_now)  st_d.lng = 1'b1;
            if (overshoot) st_d.ov  = 1'b1;
            if (st_q.driving) begin
                if (trip)                    st_d.driving = 1'b0;
                else if (st_q.cnt != CNT_MAX) st_d.cnt    = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TRIP_ENDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.driving && trip && !pwm_start && !clear) |=> !st_q.driving); // R5
    AST_LONG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lng && !pwm_start && !clear) |=> st_q.lng); // R5
    AST_NO_END_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !cycle_end || !pwm_start || $past(pwm_start) == 1'b0); // R3
endmodule

// File: rtl/adt_share_step.sv
module adt_share_step
    import adt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_mid,
    input  logic   step_en,
    input  logic   ov,
    input  logic   lng,
    output share_t share
);
    share_t share_q, share_d;

    always_comb begin
        share_d = share_q;
        if (load_mid) begin
            share_d = SHARE_MID;
        end else if (step_en) begin
            if (ov) begin
                if (share_q != SHARE_MAX) share_d = share_q + share_t'(1);
            end else if (lng) begin
                if (share_q != SHARE_MIN) share_d = share_q - share_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) share_q <= SHARE_MID;
        else        share_q <= share_d;
    end

    assign share = share_q;

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && step_en && ov && share_q != SHARE_MAX) |=> share_q == share_t'($past(share_q) + share_t'(1))); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && step_en && !ov && lng && share_q != SHARE_MIN) |=> share_q == share_t'($past(share_q) - share_t'(1))); // R5
    AST_OV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && step_en && ov && lng) |=> share_q >= $past(share_q)); // R6
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && step_en && ov && share_q == SHARE_MAX) |=> share_q == SHARE_MAX); // R7
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && step_en && !ov && lng && share_q == SHARE_MIN) |=> share_q == SHARE_MIN); // R7
    AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mid && !step_en) |=> $stable(share_q)); // R3
    AST_WAKE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        load_mid |=> share_q == SHARE_MID); // R8
endmodule

// File: rtl/adt_decay_tuner.sv
module adt_decay_tuner
    import adt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MIX_SHARE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_n,
    input  logic             tune_pin,
    input  logic [1:0]       fixed_sel,
    input  logic             pwm_start,
    input  logic             trip,
    input  logic             overshoot,
    input  logic [CNT_W-1:0] long_thresh,
    output logic [3:0]       fast_share,
    output logic             tune_active
);
    localparam share_t MIX_VAL = share_t'(MIX_SHARE);

    logic   awake, tune_on, wake_now;
    logic   cycle_end, ov_seen, long_seen, step_en;
    share_t tuned_share, fixed_share;

    adt_wake_latch u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_n  (sleep_n),
        .tune_pin (tune_pin),
        .awake    (awake),
        .tune_on  (tune_on),
        .wake_now (wake_now)
    );

    adt_drive_monitor #(.CNT_W(CNT_W)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (~awake),
        .pwm_start   (pwm_start),
        .trip        (trip),
        .overshoot   (overshoot),
        .long_thresh (long_thresh),
        .cycle_end   (cycle_end),
        .ov_seen     (ov_seen),
        .long_seen   (long_seen)
    );

    assign step_en = cycle_end & tune_on;

    adt_share_step u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_mid (wake_now),
        .step_en  (step_en),
        .ov       (ov_seen),
        .lng      (long_seen),
        .share    (tuned_share)
    );

    always_comb begin
        case (fixed_sel_e'(fixed_sel))
            SEL_FAST:  fixed_share = SHARE_MAX;
            SEL_MIXED: fixed_share = MIX_VAL;
            default:   fixed_share = SHARE_MIN;
        endcase
        if (!awake)       fast_share = SHARE_MIN;
        else if (tune_on) fast_share = tuned_share;
        else              fast_share = fixed_share;
    end

    assign tune_active = tune_on;

    AST_FIXED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        tune_active |-> fast_share == tuned_share); // R2
    AST_ASLEEP_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> (fast_share == SHARE_MIN && !tune_active)); // R9
endmodule

// File: tb/sim_adt_decay_tuner.sv
module sim_adt_decay_tuner;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_n;
    logic       tune_pin;
    logic [1:0] fixed_sel;
    logic       pwm_start;
    logic       trip;
    logic       overshoot;
    logic [7:0] long_thresh;
    logic [3:0] fast_share;
    logic       tune_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    adt_decay_tuner #(.CNT_W(8), .MIX_SHARE(5)) u0 (
        .clk, .rst_n, .sleep_n, .tune_pin, .fixed_sel, .pwm_start,
        .trip, .overshoot, .long_thresh, .fast_share, .tune_active
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_pulse();
        @(negedge clk) pwm_start = 1'b1;
        @(negedge clk) pwm_start = 1'b0;
    endtask

    // One PWM cycle: trip len edges after the start, then the next start grades it.
    task automatic cyc(input int len, input bit ov, input int exp, input string tag);
        repeat (len - 1) @(negedge clk);
        trip = 1'b1; overshoot = ov;
        @(negedge clk) trip = 1'b0; overshoot = 1'b0;
        repeat (2) @(negedge clk);
        pwm_start = 1'b1;
        @(negedge clk) pwm_start = 1'b0;
        chk(tag, fast_share, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sleep_n = 1'b0; tune_pin = 1'b0; fixed_sel = 2'b00;
        pwm_start = 1'b0; trip = 1'b0; overshoot = 1'b0; long_thresh = 8'd10;
        repeat (3) @(negedge clk);
        chk("R9 reset share", fast_share, 0);
        chk("R9 reset tune_active", tune_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 asleep after reset", fast_share, 0);
    endtask

    task automatic t_wake(input bit tune);
        tune_pin = tune; sleep_n = 1'b1;
        @(negedge clk);
        chk("R1 captured enable", tune_active, tune);
        if (tune) chk("R8 wake loads 8", fast_share, 8);
    endtask

    task automatic t_sleep();
        @(negedge clk) sleep_n = 1'b0;
        @(negedge clk);
        chk("R9 asleep share", fast_share, 0);
        chk("R9 asleep tune_active", tune_active, 0);
    endtask

    task automatic t_first_and_up();
        start_pulse();
        chk("R3 first start holds", fast_share, 8);
        for (int v = 9; v <= 15; v++) cyc(3, 1'b1, v, "R4 overshoot step up");
        cyc(3, 1'b1, 15, "R7 saturate at 15");
    endtask

    task automatic t_long();
        cyc(20, 1'b0, 14, "R5 long drive step down");
        cyc(10, 1'b0, 14, "R10 equal threshold holds");
        cyc(11, 1'b0, 13, "R5 just over threshold");
        cyc(20, 1'b1, 14, "R6 overshoot beats long");
        // R3: mid-cycle trip leaves the share until the boundary
        repeat (2) @(negedge clk);
        trip = 1'b1; overshoot = 1'b1;
        @(negedge clk) trip = 1'b0; overshoot = 1'b0;
        @(negedge clk);
        chk("R3 no change before boundary", fast_share, 14);
        start_pulse();
        chk("R3 change at boundary", fast_share, 15);
        cyc(3, 1'b0, 15, "R3 quiet cycle holds");
    endtask

    task automatic t_down_to_floor();
        for (int v = 14; v >= 0; v--) cyc(15, 1'b0, v, "R5 step down to floor");
        cyc(15, 1'b0, 0, "R7 saturate at 0");
    endtask

    task automatic t_fixed_ignored();
        @(negedge clk) fixed_sel = 2'b01;
        @(negedge clk);
        chk("R2 fixed select ignored", fast_share, 0);
        fixed_sel = 2'b10;
        cyc(3, 1'b1, 1, "R2 tuning continues");
    endtask

    task automatic t_enable_latched();
        @(negedge clk) tune_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 enable drop ignored", tune_active, 1);
        cyc(3, 1'b1, 2, "R1 still tuning");
    endtask

    task automatic t_fixed_map();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk) fixed_sel = 2'(s);
            @(negedge clk);
            chk("R9 fixed map", fast_share, (s == 1) ? 15 : (s == 2) ? 5 : 0);
        end
        @(negedge clk) tune_pin = 1'b1; fixed_sel = 2'b10;
        repeat (2) @(negedge clk);
        chk("R1 enable rise ignored", tune_active, 0);
        start_pulse();
        cyc(3, 1'b1, 5, "R1 fixed unaffected by events");
    endtask

    initial begin
        t_reset();
        t_wake(1'b1);
        t_first_and_up();
        t_long();
        t_down_to_floor();
        t_fixed_ignored();
        t_enable_latched();
        t_sleep();
        t_wake(1'b0);
        t_fixed_map();
        t_sleep();
        t_wake(1'b1);
        chk("R2 share after rewake", fast_share, 8);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule